// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Block

This block collects 64 level-sensitive interrupt request lines and keeps a 64-bit enable mask beside them. On every clock edge it copies the request lines into a pending register. It combines that register with the mask to give a masked request vector, one bit per source, and a single line that is high while any masked request is active. Position 0 is reserved: it never stands for a source, its pending bit is always 0 and its masked request is always 0.

A CPU reaches the block through a small 32-bit register bus. The bus has a select, a write strobe, a byte offset, write data, and registered read data with a valid flag. Both the pending and the mask registers appear as a high word (bits 63:32) and a low word (bits 31:0). A mask bit of 1 blocks its source. Reset sets every mask bit, so all sources start blocked. Writing the low mask word with data bit 0 set blocks every source in one access, whatever the other data bits are.

A small two-state bus engine (BUS_IDLE, BUS_RESP) handles reads. A read accepted in BUS_IDLE or BUS_RESP moves the engine to BUS_RESP, which presents the data one cycle later. A cycle with no read returns it to BUS_IDLE.

Top module: `irq_pend_mask`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, masked_req is all zero and irq_any is 0.
- R2: For i in 63:1, masked_req[i] is 1 exactly when pending bit i is 1 and mask bit i is 0. masked_req[0] is always 0.
- R3: irq_any is 1 exactly when at least one bit of masked_req is 1.
- R4: Pending bit i takes the value of src_req[i] on every rising clock edge, so a change on a source line shows on masked_req after the next edge.
- R5: Reads of the pending words (high word at offset 0x0, low word at offset 0x4) return the raw sampled source state even when the matching mask bits are 1.
- R6: Pending bit 0 always reads 0. Writes to offsets 0x0 and 0x4 change no register.
- R7: A write to the low mask word (offset 0xC) with data bit 0 equal to 1 sets all 64 mask bits to 1, regardless of the other data bits.
- R8: A write to the high mask word (offset 0x8) changes only mask bits 63:32 and never sets the low mask bits.
- R9: A read accepted on one edge returns its data on bus_rdata with bus_rvalid high during the following cycle. The pending value returned is the one sampled on the edge before the read was accepted.
- R10: A write to offset 0xC with data bit 0 equal to 0 loads mask bits 31:0 from the data and leaves bits 63:32 unchanged.
- R11: A read from any offset other than 0x0, 0x4, 0x8 or 0xC returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 64 | Level-sensitive request lines, one per source |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| masked_req | output | 64 | Pending AND NOT mask, bit 0 always 0 |
| irq_any | output | 1 | OR of masked_req |

## Verification
The pending sampler and the mask register change on the same clock edge. A low-word mask write can land while a source line is rising, and the masked output must then reflect both the new mask and the newly sampled request. The bench sets a source, unmasks it and issues the global mask-all write around the same edge. It then checks that masked_req and irq_any stay low while a read of the pending word still shows the raw request. It also puts a source change on the edge where a read is accepted, and checks that the read returns the value sampled before that edge.

// File: rtl/irq_pm_pkg.sv
package irq_pm_pkg;

    localparam logic [3:0] OFF_PEND_HI = 4'h0;
    localparam logic [3:0] OFF_PEND_LO = 4'h4;
    localparam logic [3:0] OFF_MASK_HI = 4'h8;
    localparam logic [3:0] OFF_MASK_LO = 4'hC;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    output logic [NUM_SRC-1:0] pend_q
);

    // Position 0 is reserved and never latches a request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= {src_req[NUM_SRC-1:1], 1'b0};
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWORDS-1:0]        wr_word,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NWORDS*WORD_W-1:0] mask_q
);

    logic block_all;

    // Only the lowest word, written with data bit 0 set, blocks everything.
    assign block_all = wr_word[0] & wdata[0];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g*WORD_W +: WORD_W] <= '1;
            end else if (block_all) begin
                mask_q[g*WORD_W +: WORD_W] <= '1;
            end else if (wr_word[g]) begin
                mask_q[g*WORD_W +: WORD_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_pm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*WORD_W-1:0] pend_q,
    input  logic [2*WORD_W-1:0] mask_q,
    output logic [1:0]          wr_word,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                bus_rvalid
);

    bus_state_e          state_q;
    bus_state_e          state_d;
    logic                rd_req;
    logic [WORD_W-1:0]   rd_mux;
    logic [WORD_W-1:0]   rdata_q;

    assign rd_req = bus_sel & ~bus_wr;

    // Write decode: index 0 = low mask word, index 1 = high mask word.
    always_comb begin
        wr_word = 2'b00;
        if (bus_sel && bus_wr) begin
            unique case (bus_addr)
                OFF_MASK_LO: wr_word = 2'b01;
                OFF_MASK_HI: wr_word = 2'b10;
                default:     wr_word = 2'b00;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFF_PEND_HI: rd_mux = pend_q[2*WORD_W-1:WORD_W];
            OFF_PEND_LO: rd_mux = pend_q[WORD_W-1:0];
            OFF_MASK_HI: rd_mux = mask_q[2*WORD_W-1:WORD_W];
            OFF_MASK_LO: rd_mux = mask_q[WORD_W-1:0];
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: capture read data when a read is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_mux;
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rvalid = (state_q == BUS_RESP);
    assign bus_rdata  = rdata_q;

endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4,
    localparam int NUM_SRC = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    output logic [NUM_SRC-1:0] masked_req,
    output logic               irq_any
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [1:0]         wr_word;

    irq_pend_sampler #(.NUM_SRC(NUM_SRC)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .pend_q  (pend_q)
    );

    irq_mask_bank #(.WORD_W(WORD_W), .NWORDS(2)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_word (wr_word),
        .wdata   (bus_wdata),
        .mask_q  (mask_q)
    );

    irq_bus_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .wr_word    (wr_word),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    assign masked_req = pend_q & ~mask_q & {{(NUM_SRC-1){1'b1}}, 1'b0};
    assign irq_any    = |masked_req;

endmodule

// File: rtl/irq_pend_mask_chk.sv
module irq_pend_mask_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*WORD_W-1:0] src_req,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic [WORD_W-1:0]   bus_rdata,
    input logic                bus_rvalid,
    input logic [2*WORD_W-1:0] masked_req,
    input logic                irq_any,
    input logic [2*WORD_W-1:0] mask_q
);

    // R1: mask fully set when reset is released.
    a_r1_reset_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && masked_req == '0));

    // R2 / R4: masked output follows the source line sampled on the previous edge.
    a_r4_sample_path: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (masked_req == ($past(src_req) & ~mask_q & ~64'd1)));

    // R3: combined line agrees with the per-source vector.
    a_r3_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (masked_req != '0));

    // R7: low-word write with data bit 0 set blocks everything.
    a_r7_block_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'hC && bus_wdata[0]) |=> (mask_q == '1));

    // R8: high-word write leaves the low mask word alone.
    a_r8_high_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'h8) |=> (mask_q[WORD_W-1:0] == $past(mask_q[WORD_W-1:0])));

    // R9: read data valid one cycle after the read.
    a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R6: reserved pending position reads 0.
    a_r6_pend_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 4'h4) |=> (bus_rdata[0] == 1'b0));

endmodule

bind irq_pend_mask irq_pend_mask_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .masked_req (masked_req),
    .irq_any    (irq_any),
    .mask_q     (mask_q)
);

// File: tb/irq_pend_mask_bench.sv
module irq_pend_mask_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [63:0] masked_req;
    logic        irq_any;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    irq_pend_mask u_irq_pend_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .masked_req (masked_req),
        .irq_any    (irq_any)
    );

    typedef struct packed {
        logic [63:0] src;
        logic [31:0] mhi;
        logic [31:0] mlo;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{src: 64'h0000_0000_0000_0002, mhi: 32'hFFFF_FFFF, mlo: 32'h0000_0000},
        '{src: 64'h8000_0000_0000_0000, mhi: 32'h0000_0000, mlo: 32'hFFFF_FFFE},
        '{src: 64'hF0F0_F0F0_0F0F_0F0F, mhi: 32'h00FF_00FF, mlo: 32'h0F00_F000},
        '{src: 64'hFFFF_FFFF_FFFF_FFFF, mhi: 32'h0000_0000, mlo: 32'h0000_0000},
        '{src: 64'h0000_0000_0000_0001, mhi: 32'h0000_0000, mlo: 32'h0000_0000},
        '{src: 64'hFFFF_FFFF_FFFF_FFFF, mhi: 32'h0000_0000, mlo: 32'h1234_5671}
    };

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic        rv;
        logic [63:0] mexp;
        logic [63:0] exp;

        repeat (3) @(negedge clk);
        src_req = 64'hFFFF_0000_0000_FFFF;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: sources active but masked after reset
        check64("R1 masked_req", masked_req, 64'h0);
        check64("R1 irq_any", {63'd0, irq_any}, 64'd0);
        bus_read(4'hC, rd, rv);
        check64("R1 mask lo", {32'd0, rd}, 64'hFFFF_FFFF);
        bus_read(4'h8, rd, rv);
        check64("R1 mask hi", {32'd0, rd}, 64'hFFFF_FFFF);
        // R5: pending visible though masked; R6: bit 0 reads 0
        bus_read(4'h4, rd, rv);
        check64("R5 R6 pend lo", {32'd0, rd}, 64'h0000_FFFE);
        bus_read(4'h0, rd, rv);
        check64("R5 pend hi", {32'd0, rd}, 64'hFFFF_0000);
        check64("R9 rvalid", {63'd0, rv}, 64'd1);

        // Table walk: R2, R3, R4, R7, R10
        for (int i = 0; i < 6; i++) begin
            bus_write(4'h8, VECS[i].mhi);
            bus_write(4'hC, VECS[i].mlo);
            mexp = VECS[i].mlo[0] ? 64'hFFFF_FFFF_FFFF_FFFF : {VECS[i].mhi, VECS[i].mlo};
            src_req = VECS[i].src;
            @(negedge clk);
            exp = VECS[i].src & ~mexp & ~64'd1;
            check64("R2 R4 masked_req", masked_req, exp);
            check64("R3 irq_any", {63'd0, irq_any}, {63'd0, (exp != 64'd0)});
        end

        // R7: mask-all with other data bits zero after full unmask
        bus_write(4'h8, 32'h0);
        bus_write(4'hC, 32'h0);
        src_req = 64'h0000_0400_0000_0010;
        @(negedge clk);
        check64("R2 unmasked", masked_req, 64'h0000_0400_0000_0010);
        bus_write(4'hC, 32'h0000_0001);
        check64("R7 masked_req", masked_req, 64'h0);
        bus_read(4'h8, rd, rv);
        check64("R7 mask hi", {32'd0, rd}, 64'hFFFF_FFFF);
        bus_read(4'h0, rd, rv);
        check64("R5 pend hi masked", {32'd0, rd}, 64'h0000_0400);

        // R8: high write leaves low word, no mask-all even with bit 0 set
        bus_write(4'h8, 32'h0000_0001);
        bus_read(4'hC, rd, rv);
        check64("R8 mask lo kept", {32'd0, rd}, 64'hFFFF_FFFF);
        bus_read(4'h8, rd, rv);
        check64("R8 mask hi", {32'd0, rd}, 64'h0000_0001);

        // R10: low write without bit 0 leaves the high word
        bus_write(4'hC, 32'hA5A5_0000);
        bus_read(4'h8, rd, rv);
        check64("R10 mask hi kept", {32'd0, rd}, 64'h0000_0001);
        bus_read(4'hC, rd, rv);
        check64("R10 mask lo", {32'd0, rd}, 64'hA5A5_0000);

        // R6: writes to pending words ignored
        src_req = 64'h1111_2222_3333_4444;
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_write(4'h0, 32'h0);
        bus_read(4'h4, rd, rv);
        check64("R6 pend lo", {32'd0, rd}, 64'h3333_4444);
        bus_read(4'h0, rd, rv);
        check64("R6 pend hi", {32'd0, rd}, 64'h1111_2222);

        // R9: source changes on the edge the read is accepted
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4;
        src_req = 64'h0000_0000_0000_0080;
        @(negedge clk);
        bus_sel = 1'b0;
        check64("R9 old sample", {32'd0, bus_rdata}, 64'h3333_4444);

        // R11: unmapped offsets
        bus_read(4'h2, rd, rv);
        check64("R11 unmapped 2", {32'd0, rd}, 64'h0);
        bus_read(4'hD, rd, rv);
        check64("R11 unmapped D", {32'd0, rd}, 64'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule